// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block connects a synchronous system to an external static RAM that has no clock: 32768 words of 8 bits, an active-low chip select, an active-low output enable and an active-low write strobe. The user side hands over one access at a time through a ready/valid port. Each access carries an address, a write flag and write data. The block later answers with a one-cycle acknowledge, and with read data when the access was a read.

On the memory side the block places the address. It then opens the chip select, and only after that does it open either the output enable or the write strobe. Each strobe is held for a whole number of clock cycles. Those counts come from nanosecond-style limits given as parameters and are rounded up against the clock period. The write is performed by the window in which both the chip select and the write strobe are low. The block drives write data into that window and keeps it on the bus for one cycle after the write strobe closes.

After every read, the block waits a parameterised number of cycles with the memory deselected. This lets the memory release the shared data bus. Whenever no access is in progress the chip select stays high, which keeps the memory in standby.

Top module: `asram_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the chip select, output enable and write strobe (all active low) are 1, the data-bus output enable is 0, the acknowledge is 0 and ready is 1.
- R2: In a read, the chip select goes low one cycle before the output enable. The output enable then stays low for RD_CYC+1 cycles, the write strobe stays 1 throughout, and the data is sampled at the clock edge that ends the last output-enable-low cycle.
- R3: In a write, the chip select goes low one cycle before the write strobe. The write strobe is low for exactly WR_CYC cycles, and the chip select stays low for one more cycle after it. The output enable stays 1 for the whole write, and the memory stores the write data.
- R4: The data-bus output enable is 1 only while the write strobe is low and in the single cycle after it rises (WR_CYC+1 cycles per write). It is never 1 while the output enable is low.
- R5: While the chip select is low, the memory address equals the address accepted with the request, even if the request inputs change after acceptance.
- R6: For a read accepted at a clock edge, rsp_ack is 1 for one cycle after the (RD_CYC+2)th following edge, and rsp_rdata then holds the memory word at that address.
- R7: For a write accepted at a clock edge, rsp_ack is 1 for one cycle after the (WR_CYC+2)th following edge. No acknowledge lasts more than one cycle.
- R8: After a read acknowledge, the chip select, output enable and write strobe stay 1 and ready stays 0 for TA_CYC cycles. Ready returns RD_CYC+TA_CYC+2 edges after acceptance.
- R9: Ready is 0 from the accepting edge until the access is over, so no new request is taken meanwhile. After a write, ready returns in the same cycle as the acknowledge.
- R10: Whenever ready is 1, the chip select, output enable and write strobe are 1 and the data-bus output enable is 0.
- R11: Asserting reset during a write releases all strobes to 1 and the data-bus output enable to 0 without waiting for a clock edge.
- R12: RD_CYC = max(ceil(T_AA/CLK), ceil(T_OE/CLK), 1), WR_CYC = max(ceil(T_WP/CLK), ceil(T_DS/CLK), 1) and TA_CYC = max(ceil(T_HZ/CLK), 1), where all times are in picoseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Data of the last read |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data-bus driver |
| mem_dq_in | input | DATA_W | Data returned from the memory |

## Verification
A sequencer stuck in or skipping a state shows up within one access as a wrong count of strobe-low cycles, or as an acknowledge on the wrong edge. A wait counter that is off by one moves the read sample point; the memory model returns junk until the output enable has been low long enough, so the wrong rsp_rdata is visible at the very next acknowledge. A strobe decoded from the wrong state shows as a driven data bus while the output enable is low, or as a write window without data, and the memory model exposes this on the next read.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURN
  } asram_state_e;

  // whole clock cycles covering a time limit
  function automatic int unsigned cycles_for(int unsigned t_ps, int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_dwell.sv
// Down counter that times how long a state lasts.
module asram_dwell #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;

  assign cnt_en  = load | (cnt_q != '0);
  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= load ? load_val : (cnt_q - 1'b1);
    end
  end
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int unsigned RD_CYC = 1,
  parameter int unsigned WR_CYC = 1,
  parameter int unsigned TA_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe,
  output logic ack
);
  localparam int unsigned MAXC  = max3(RD_CYC, WR_CYC, TA_CYC);
  localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

  asram_state_e     st_q, st_d;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             expired;

  asram_dwell #(.CNT_W(CNT_W)) u_dwell (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .expired  (expired)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready & req_valid;
  assign capture   = (st_q == ST_RD_CAPTURE);

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (st_q)
      ST_IDLE:       if (req_valid) st_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
      ST_RD_SETUP:   begin st_d = ST_RD_WAIT;  cnt_load = 1'b1; cnt_val = RD_LOAD; end
      ST_RD_WAIT:    if (expired) st_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: begin st_d = ST_TURN;     cnt_load = 1'b1; cnt_val = TA_LOAD; end
      ST_TURN:       if (expired) st_d = ST_IDLE;
      ST_WR_SETUP:   begin st_d = ST_WR_PULSE; cnt_load = 1'b1; cnt_val = WR_LOAD; end
      ST_WR_PULSE:   if (expired) st_d = ST_WR_RECOVER;
      ST_WR_RECOVER: st_d = ST_IDLE;
      default:       st_d = ST_IDLE;
    endcase
  end

  // strobes come straight from flops, decoded from the next state
  logic ce_d, oe_d, we_d, dq_oe_d, ack_d;
  always_comb begin
    ce_d    = !((st_d == ST_IDLE) || (st_d == ST_TURN));
    oe_d    = (st_d == ST_RD_WAIT) || (st_d == ST_RD_CAPTURE);
    we_d    = (st_d == ST_WR_PULSE);
    dq_oe_d = (st_d == ST_WR_PULSE) || (st_d == ST_WR_RECOVER);
    ack_d   = (st_q == ST_RD_CAPTURE) || (st_q == ST_WR_RECOVER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      ack   <= 1'b0;
    end else begin
      st_q  <= st_d;
      ce_n  <= ~ce_d;
      oe_n  <= ~oe_d;
      we_n  <= ~we_d;
      dq_oe <= dq_oe_d;
      ack   <= ack_d;
    end
  end
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_rdata <= mem_dq_in;
    end
  end
endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_PS  = 10000,
  parameter int unsigned T_WP_PS = 8000,
  parameter int unsigned T_DS_PS = 6000,
  parameter int unsigned T_AA_PS = 10000,
  parameter int unsigned T_OE_PS = 5000,
  parameter int unsigned T_HZ_PS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned RD_CYC = max3(cycles_for(T_AA_PS, CLK_PS), cycles_for(T_OE_PS, CLK_PS), 1);
  localparam int unsigned WR_CYC = max3(cycles_for(T_WP_PS, CLK_PS), cycles_for(T_DS_PS, CLK_PS), 1);
  localparam int unsigned TA_CYC = max3(cycles_for(T_HZ_PS, CLK_PS), 1, 1);

  logic accept, capture;

  asram_fsm #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe),
    .ack       (rsp_ack)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_rdata  (rsp_rdata)
  );
endmodule

// File: rtl/asram_checker.sv
module asram_checker #(
  parameter int unsigned AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_ack,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr
);
  p_read_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  p_write_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  p_idle_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));
endmodule

bind asram_sequencer asram_checker #(.AW(ADDR_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_ack   (rsp_ack),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/asram_sequencer_test.sv
module asram_sequencer_test;
  // expected cycle counts from R12 with the parameters below
  localparam int WRC = 3;  // max(ceil(25/10), ceil(12/10))
  localparam int RDC = 2;  // max(ceil(20/10), ceil(5/10))
  localparam int TAC = 2;  // ceil(15/10)

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready, rsp_ack;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata, rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #5 clk = ~clk;

  asram_sequencer #(
    .CLK_PS(10000), .T_WP_PS(25000), .T_DS_PS(12000),
    .T_AA_PS(20000), .T_OE_PS(5000), .T_HZ_PS(15000)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: write on the closing edge of the select/strobe overlap
  logic [7:0] sram [int unsigned];
  logic [7:0] ref_mem [int unsigned];
  logic       wr_end;
  int         oe_cnt;
  assign wr_end = mem_ce_n | mem_we_n;

  always @(posedge wr_end)
    if (rst_n === 1'b1 && mem_dq_oe === 1'b1) sram[int'(mem_addr)] = mem_dq_out;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) oe_cnt <= 0;
    else if (!mem_oe_n && !mem_ce_n) oe_cnt <= oe_cnt + 1;
    else oe_cnt <= 0;

  function automatic logic [7:0] model_rd(input logic [14:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : 8'h5A;
  endfunction

  // junk until the output enable has been low long enough
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n && oe_cnt >= RDC)
                     ? model_rd(mem_addr) : 8'hC3;

  // scoreboard
  typedef struct { bit is_wr; logic [7:0] data; } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n && rsp_ack) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected ack", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        if (!e.is_wr) chk(rsp_rdata == e.data, "R6 read data", rsp_rdata, e.data);
      end
    end
  end

  task automatic access(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int n, ack_n, ack_cnt, ready_n, we_lo, oe_lo, dq_cnt, addr_bad, ce_idle_busy, clash;
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (wr) ref_mem[int'(a)] = d;
    e.is_wr = wr;
    e.data  = wr ? d : ref_mem[int'(a)];
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
    n = 1; ack_n = 0; ack_cnt = 0; ready_n = 0; we_lo = 0; oe_lo = 0;
    dq_cnt = 0; addr_bad = 0; ce_idle_busy = 0; clash = 0;
    while (n < 40) begin
      if (!mem_we_n) we_lo++;
      if (!mem_oe_n) oe_lo++;
      if (mem_dq_oe) dq_cnt++;
      if (mem_dq_oe && !mem_oe_n) clash++;
      if (!mem_ce_n && mem_addr != a) addr_bad++;
      if (rsp_ack) begin ack_cnt++; if (ack_n == 0) ack_n = n; end
      if (req_ready) begin ready_n = n; break; end
      if (mem_ce_n) ce_idle_busy++;
      n++;
      @(negedge clk);
    end
    chk(addr_bad == 0, "R5 address stable", addr_bad, 0);
    chk(clash == 0, "R4 no drive while output enabled", clash, 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R10 idle deselect",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    if (wr) begin
      chk(we_lo == WRC, "R3 write strobe width", we_lo, WRC);
      chk(oe_lo == 0, "R3 output enable high in write", oe_lo, 0);
      chk(dq_cnt == WRC + 1, "R4 bus drive cycles", dq_cnt, WRC + 1);
      chk(ack_n == WRC + 3 && ack_cnt == 1, "R7 write ack timing", ack_n, WRC + 3);
      chk(ready_n == WRC + 3, "R9 ready after write", ready_n, WRC + 3);
      chk(ce_idle_busy == 0, "R3 select held through write", ce_idle_busy, 0);
      chk(model_rd(a) == d, "R3 memory content", model_rd(a), d);
    end else begin
      chk(oe_lo == RDC + 1, "R2 output enable width", oe_lo, RDC + 1);
      chk(we_lo == 0, "R2 write strobe high in read", we_lo, 0);
      chk(dq_cnt == 0, "R4 no drive in read", dq_cnt, 0);
      chk(ack_n == RDC + 3 && ack_cnt == 1, "R6 read ack timing", ack_n, RDC + 3);
      chk(ready_n == RDC + TAC + 3, "R8 ready after turnaround", ready_n, RDC + TAC + 3);
      chk(ce_idle_busy == TAC, "R8 deselected turnaround", ce_idle_busy, TAC);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_ack && req_ready,
        "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_ack, req_ready}, 6'b111001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_ack && req_ready,
        "R1 after release", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_ack, req_ready}, 6'b111001);

    access(1'b1, 15'h0000, 8'h00);
    access(1'b1, 15'h7FFF, 8'hFF);
    access(1'b1, 15'h1234, 8'h5A);
    access(1'b0, 15'h7FFF, 8'h00);
    access(1'b1, 15'h4AA5, 8'hA5);
    access(1'b0, 15'h0000, 8'h00);
    access(1'b0, 15'h1234, 8'h00);
    access(1'b0, 15'h1234, 8'h00);
    access(1'b1, 15'h1234, 8'h3C);
    access(1'b0, 15'h1234, 8'h00);
    access(1'b0, 15'h4AA5, 8'h00);

    // R11: reset in the middle of a write pulse
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0101; req_wdata = 8'h77;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    chk(!mem_we_n && mem_dq_oe, "R11 write in progress", {mem_we_n, mem_dq_oe}, 2'b01);
    #2 rst_n = 1'b0;
    #1;
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_ack, "R11 async release",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_ack}, 5'b11100);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R11 ready after reset", req_ready, 1);

    access(1'b0, 15'h7FFF, 8'h00);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all acks seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule